// File: doc/BRIEF.md
# Paged Alert Mask Controller

This block decides when the active-low PMBus SMBALERT line is driven. It watches a set of status flags: seven sources that both output channels share (communication and memory faults, the manufacturer-specific flag) and eight sources per channel (temperature, current, voltage, power-good and input undervoltage conditions). A 16-bit mask word controls which flags may pull the line. Its upper byte is a single common copy. Its lower byte is banked, with one copy per channel, and the current page chooses which bank is read or written.

Bit 8 of the mask word enables automatic alert-response masking. While it is on, an `ara_ack` strobe moves every source that is set at that instant into a hidden mask. A stuck fault therefore cannot keep re-asserting the alert line and win every later alert-response round. Hidden entries clear when their flag clears, or on a `clear_faults` pulse. Certain write-protect values force the automatic mode on.

The alert line comes from a two-state machine. `ALRT_IDLE` releases the line (high) and `ALRT_DRIVE` pulls it low. The transition RAISE goes from idle to drive when an unmasked source is pending. The transition RELEASE goes from drive to idle when none is pending. In every other case the machine stays in its current state.

Top module: `alert_mask_ctrl`

## Requirements
- R1: After reset the mask word reads 0000h, `smbalert_n` is high, and the hidden auto mask is empty.
- R2: Bits 15..8 of the mask word are one common register. A write on any page changes it, and every page reads the same value.
- R3: Bits 7..0 are banked per page. A write changes only the bank selected by `page_sel`, and a read returns that bank.
- R4: Mask bit 1 blocks its source and mask bit 0 has no effect. `shared_stat[i]` is blocked by word bit 9+i for i = 0..6. `paged_stat[8*p+j]` is blocked by bank p bit j.
- R5: A write with bit 8 set and any other bit set stores only 0100h, with the current page's bank cleared, and that corrected value reads back.
- R6: `smbalert_n` goes low one clock after any source of either page or of the shared set is set and neither user-masked nor auto-masked. It goes high one clock after no such source remains.
- R7: While auto mode is on, an `ara_ack` strobe adds every currently set source to the hidden mask. While auto mode is off, `ara_ack` adds nothing.
- R8: A hidden-mask entry is dropped in the cycle its flag is low, and the whole hidden mask is cleared by `clear_faults`.
- R9: A `wp_value` of 20h, 40h or 80h forces auto mode on, and read bit 8 then reads 1. Any other value leaves auto mode to the stored bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Mask word write strobe |
| wr_data | input | 16 | Mask word write value |
| rd_data | output | 16 | Mask word as seen from the current page |
| page_sel | input | 1 | Selected channel page |
| wp_value | input | 8 | Write-protect setting |
| shared_stat | input | 7 | Shared source flags |
| paged_stat | input | 16 | Per-page source flags, page p in bits 8p+7..8p |
| ara_ack | input | 1 | Alert-response answered strobe |
| clear_faults | input | 1 | Clears the hidden auto mask |
| smbalert_n | output | 1 | Active-low alert |

## Verification
The bench raises a flag on page 1 while page 0 is selected. A design that only looked at the selected page would then leave the alert released. It writes the upper byte from one page and reads it back from the other, and it writes one bank and checks that the other is untouched, which exposes a design that keeps shared and banked storage mixed up. It sends combined writes that set bit 8 with other bits, expecting the corrected 0100h. It sends `ara_ack` with auto mode off, with auto mode on, and with auto mode forced by each write-protect value and by a near miss. It then drops and re-raises a captured flag, so that a hidden mask which never releases leaves the line high, and one that captures too eagerly silences it.

// File: rtl/alert_mask_pkg.sv
package alert_mask_pkg;

    localparam int unsigned BYTE_W   = 8;
    localparam int unsigned WORD_W   = 2 * BYTE_W;
    localparam int unsigned SHARED_N = BYTE_W - 1;

    typedef enum logic [0:0] {
        ALRT_IDLE  = 1'b0,
        ALRT_DRIVE = 1'b1
    } alrt_state_e;

    function automatic logic wp_forces_auto(input logic [7:0] wp);
        return (wp == 8'h20) || (wp == 8'h40) || (wp == 8'h80);
    endfunction

endpackage

// File: rtl/amc_mask_bank.sv
module amc_mask_bank
    import alert_mask_pkg::*;
#(
    parameter int unsigned NUM_PAGES = 2,
    parameter int unsigned PAGE_W    = 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [WORD_W-1:0]           wr_data,
    input  logic [PAGE_W-1:0]           page_sel,
    input  logic                        force_auto,
    output logic [WORD_W-1:0]           rd_data,
    output logic [BYTE_W-1:0]           shared_q,
    output logic [NUM_PAGES*BYTE_W-1:0] bank_flat
);

    logic [WORD_W-1:0] wr_fix;
    logic [BYTE_W-1:0] bank_q [NUM_PAGES];
    logic [BYTE_W-1:0] rd_lo;

    always_comb begin
        wr_fix = wr_data;
        if (wr_data[BYTE_W] && ((wr_data & ~(WORD_W'(1) << BYTE_W)) != '0)) begin
            wr_fix = WORD_W'(1) << BYTE_W;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shared_q <= '0;
        end else if (wr_en) begin
            shared_q <= wr_fix[WORD_W-1:BYTE_W];
        end
    end

    for (genvar p = 0; p < NUM_PAGES; p++) begin : g_bank
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bank_q[p] <= '0;
            end else if (wr_en && (page_sel == PAGE_W'(p))) begin
                bank_q[p] <= wr_fix[BYTE_W-1:0];
            end
        end
        assign bank_flat[p*BYTE_W +: BYTE_W] = bank_q[p];

        AST_OTHER_BANK_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && (page_sel != PAGE_W'(p))) |=> $stable(bank_q[p])); // R3
    end

    always_comb begin
        rd_lo = '0;
        for (int p = 0; p < NUM_PAGES; p++) begin
            if (page_sel == PAGE_W'(p)) rd_lo = bank_q[p];
        end
    end

    assign rd_data = {shared_q[BYTE_W-1:1], shared_q[0] | force_auto, rd_lo};

    AST_AUTO_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
        shared_q[0] |-> (shared_q[BYTE_W-1:1] == '0)); // R5

    AST_SHARED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(shared_q)); // R2

endmodule

// File: rtl/amc_auto_mask.sv
module amc_auto_mask #(
    parameter int unsigned SRC_N = 23
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_N-1:0] flags,
    input  logic             auto_en,
    input  logic             ara_ack,
    input  logic             clear_faults,
    output logic [SRC_N-1:0] amask_q
);

    logic [SRC_N-1:0] grab;
    logic [SRC_N-1:0] amask_d;

    always_comb begin
        grab    = (ara_ack && auto_en) ? flags : '0;
        amask_d = clear_faults ? '0 : ((amask_q | grab) & flags);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) amask_q <= '0;
        else        amask_q <= amask_d;
    end

    AST_ENTRY_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((amask_q & ~$past(flags)) == '0)); // R8

    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        clear_faults |=> (amask_q == '0)); // R8

    AST_NO_GROWTH_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !auto_en |=> ((amask_q & ~$past(amask_q)) == '0)); // R7

endmodule

// File: rtl/amc_alert_fsm.sv
module amc_alert_fsm
    import alert_mask_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pending,
    output logic smbalert_n
);

    alrt_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ALRT_IDLE:  if (pending)  state_d = ALRT_DRIVE;  // RAISE
            ALRT_DRIVE: if (!pending) state_d = ALRT_IDLE;   // RELEASE
            default:                  state_d = ALRT_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ALRT_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        smbalert_n = (state_q != ALRT_DRIVE);
    end

    AST_DRIVE_HAD_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(smbalert_n) |-> $past(pending)); // R6

endmodule

// File: rtl/alert_mask_ctrl.sv
module alert_mask_ctrl
    import alert_mask_pkg::*;
#(
    parameter int unsigned NUM_PAGES = 2,
    localparam int unsigned PAGE_W   = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1,
    localparam int unsigned PAGED_N  = NUM_PAGES * BYTE_W,
    localparam int unsigned SRC_N    = PAGED_N + SHARED_N
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [WORD_W-1:0]   wr_data,
    output logic [WORD_W-1:0]   rd_data,
    input  logic [PAGE_W-1:0]   page_sel,
    input  logic [7:0]          wp_value,
    input  logic [SHARED_N-1:0] shared_stat,
    input  logic [PAGED_N-1:0]  paged_stat,
    input  logic                ara_ack,
    input  logic                clear_faults,
    output logic                smbalert_n
);

    logic                force_auto;
    logic                auto_en;
    logic [BYTE_W-1:0]   shared_q;
    logic [PAGED_N-1:0]  bank_flat;
    logic [SRC_N-1:0]    flags;
    logic [SRC_N-1:0]    user_mask;
    logic [SRC_N-1:0]    amask_q;
    logic                pending;

    assign force_auto = wp_forces_auto(wp_value);

    amc_mask_bank #(.NUM_PAGES(NUM_PAGES), .PAGE_W(PAGE_W)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .page_sel   (page_sel),
        .force_auto (force_auto),
        .rd_data    (rd_data),
        .shared_q   (shared_q),
        .bank_flat  (bank_flat)
    );

    assign auto_en   = shared_q[0] | force_auto;
    assign flags     = {paged_stat, shared_stat};
    assign user_mask = {bank_flat, shared_q[BYTE_W-1:1]};

    amc_auto_mask #(.SRC_N(SRC_N)) u_auto (
        .clk          (clk),
        .rst_n        (rst_n),
        .flags        (flags),
        .auto_en      (auto_en),
        .ara_ack      (ara_ack),
        .clear_faults (clear_faults),
        .amask_q      (amask_q)
    );

    assign pending = |(flags & ~user_mask & ~amask_q);

    amc_alert_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .pending    (pending),
        .smbalert_n (smbalert_n)
    );

    AST_QUIET_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        ((shared_stat == '0) && (paged_stat == '0)) |=> smbalert_n); // R6

    AST_FORCED_READS_ON: assert property (@(posedge clk) disable iff (!rst_n)
        ((wp_value == 8'h20) || (wp_value == 8'h40) || (wp_value == 8'h80)) |-> rd_data[BYTE_W]); // R9

endmodule

// File: tb/alert_mask_ctrl_tb.sv
module alert_mask_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic [0:0]  page_sel = '0;
    logic [7:0]  wp_value = '0;
    logic [6:0]  shared_stat = '0;
    logic [15:0] paged_stat = '0;
    logic        ara_ack = 1'b0;
    logic        clear_faults = 1'b0;
    logic        smbalert_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    bit live = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    alert_mask_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .page_sel(page_sel), .wp_value(wp_value),
        .shared_stat(shared_stat), .paged_stat(paged_stat),
        .ara_ack(ara_ack), .clear_faults(clear_faults), .smbalert_n(smbalert_n)
    );

    // behavioural reference
    bit [7:0]  m_shared;
    bit [7:0]  m_bank [2];
    bit [22:0] m_hidden;
    bit        m_alert_n;

    function automatic bit forced(input logic [7:0] w);
        return w == 8'h20 || w == 8'h40 || w == 8'h80;
    endfunction

    function automatic bit [15:0] exp_rd();
        return {m_shared[7:1], m_shared[0] | forced(wp_value), m_bank[page_sel]};
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_shared = 0; m_bank[0] = 0; m_bank[1] = 0; m_hidden = 0; m_alert_n = 1;
        end else begin
            bit [22:0] f, um, nh;
            bit        au, pend;
            f    = {paged_stat, shared_stat};
            um   = {m_bank[1], m_bank[0], m_shared[7:1]};
            au   = m_shared[0] | forced(wp_value);
            pend = (f & ~um & ~m_hidden) != 0;
            if (clear_faults) nh = 0;
            else nh = (m_hidden | ((ara_ack && au) ? f : 23'd0)) & f;
            m_hidden  = nh;
            m_alert_n = !pend;
            if (wr_en) begin
                if (wr_data[8] && (wr_data & 16'hFEFF) != 0) begin
                    m_shared = 8'h01; m_bank[page_sel] = 8'h00;
                end else begin
                    m_shared = wr_data[15:8]; m_bank[page_sel] = wr_data[7:0];
                end
            end
        end
    end

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (live) begin
            check("R6 alert level", {15'd0, smbalert_n}, {15'd0, m_alert_n});
            check("R2 R3 readback", rd_data, exp_rd());
        end
    end

    task automatic tick(); @(posedge clk); #2; endtask
    task automatic settle(); @(negedge clk); endtask

    task automatic write_mask(input logic [0:0] pg, input logic [15:0] v);
        page_sel = pg; wr_data = v; wr_en = 1'b1;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic pulse_ara();
        ara_ack = 1'b1; tick(); ara_ack = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        live = 1'b1;
        settle();
        check("R1 reset mask", rd_data, 16'h0000);
        check("R1 reset alert", {15'd0, smbalert_n}, 16'd1);

        // R6 shared source raises the line one clock later
        shared_stat = 7'b0000100; tick(); settle();
        check("R6 shared raise", {15'd0, smbalert_n}, 16'd0);
        // R4 mask shared bit 2 -> word bit 11
        write_mask(1'b0, 16'h0800); tick(); settle();
        check("R4 shared masked", {15'd0, smbalert_n}, 16'd1);
        write_mask(1'b0, 16'h0000); tick(); settle();
        check("R4 unmask reasserts", {15'd0, smbalert_n}, 16'd0);
        shared_stat = '0; tick(); tick(); settle();
        check("R6 release", {15'd0, smbalert_n}, 16'd1);

        // R6 page-1 source while page 0 selected
        page_sel = 1'b0; paged_stat = 16'h2000; tick(); tick(); settle();
        check("R6 other page raises", {15'd0, smbalert_n}, 16'd0);
        write_mask(1'b1, 16'h4020); tick(); settle();
        check("R4 paged masked", {15'd0, smbalert_n}, 16'd1);
        page_sel = 1'b0; settle();
        check("R3 bank0 untouched", rd_data, 16'h4000);
        check("R2 shared same on page0", {8'd0, rd_data[15:8]}, 16'h0040);
        page_sel = 1'b1; settle();
        check("R3 bank1 holds", rd_data, 16'h4020);
        write_mask(1'b0, 16'h0000); paged_stat = '0; tick(); settle();

        // R5 combined write corrected
        page_sel = 1'b1; write_mask(1'b1, 16'h8155); settle();
        check("R5 corrected readback", rd_data, 16'h0100);
        write_mask(1'b1, 16'h0000); settle();

        // R7 auto mode off: ara ignored
        paged_stat = 16'h0001; tick(); tick(); settle();
        check("R6 paged raise", {15'd0, smbalert_n}, 16'd0);
        pulse_ara(); tick(); tick(); settle();
        check("R7 ara ignored when off", {15'd0, smbalert_n}, 16'd0);

        // R7 auto mode on: ara captures
        write_mask(1'b0, 16'h0100); pulse_ara(); tick(); settle();
        check("R7 ara captures", {15'd0, smbalert_n}, 16'd1);
        shared_stat = 7'b1000000; tick(); tick(); settle();
        check("R7 new source still alerts", {15'd0, smbalert_n}, 16'd0);
        shared_stat = '0; tick(); tick();
        // R8 flag drop releases capture
        paged_stat = '0; tick(); paged_stat = 16'h0001; tick(); tick(); settle();
        check("R8 re-raise after drop", {15'd0, smbalert_n}, 16'd0);
        pulse_ara(); tick(); settle();
        check("R7 recapture", {15'd0, smbalert_n}, 16'd1);
        clear_faults = 1'b1; tick(); clear_faults = 1'b0; tick(); tick(); settle();
        check("R8 clear_faults empties", {15'd0, smbalert_n}, 16'd0);
        write_mask(1'b0, 16'h0000); tick();

        // R9 forced auto mode by write-protect
        foreach (wp_value[i]) begin end
        for (int k = 0; k < 4; k++) begin
            logic [7:0] w;
            w = (k == 0) ? 8'h20 : (k == 1) ? 8'h40 : (k == 2) ? 8'h80 : 8'h41;
            wp_value = w; tick(); tick(); settle();
            check("R9 bit8 readback", {15'd0, rd_data[8]}, {15'd0, k != 3});
            pulse_ara(); tick(); settle();
            check("R9 forced capture", {15'd0, smbalert_n}, {15'd0, k != 3});
            clear_faults = 1'b1; tick(); clear_faults = 1'b0; tick(); tick();
        end
        wp_value = '0; paged_stat = '0;
        repeat (4) tick();
        settle();
        finish_run();
    end

endmodule